// File: doc/BRIEF.md
# Stack Instruction Bus-Cycle Sequencer

This block sequences the bus activity of the stack-related single-byte instructions of an 8-bit processor core: push accumulator, pull accumulator, return from subroutine, stack-pointer-to-index transfer and index-to-stack-pointer transfer. Any other instruction code is run as a plain two-cycle inherent operation. The block owns the stack pointer, index register, accumulator and program counter used by these instructions.

The fetch logic latches an opcode and hands it over with a one-cycle `start` pulse, together with the address the opcode was fetched from. The sequencer then produces one bus cycle per clock. In each cycle it drives the address, the valid-memory-address line, the read/write line and the write-data enable. Every instruction keeps its full, fixed cycle pattern, including the dummy cycles whose address is presented with VMA low or whose data is discarded. External memory therefore sees exactly the per-cycle pattern that a cycle-accurate core produces. `done` marks the last cycle of each instruction.

Top module: `stackseq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `vma` and `dataOe` are 0, `rw` is 1, and `sp`, `ix`, `acc` and `pc` hold the SP_INIT, IX_INIT, ACC_INIT and PC_INIT parameter values (defaults 0x00F0, 0x0000, 0x5A, 0x0000).
- R2: A `start` sampled while idle begins an instruction on the next clock. Cycle 1 presents `opcAddrIn` and cycle 2 presents `opcAddrIn`+1. Both cycles are reads with VMA high.
- R3: The 3-bit `op` code selects the instruction: 1 push, 2 pull, 3 return, 4 stack-pointer-to-index, 5 index-to-stack-pointer. Codes 0, 6 and 7 run a 2-cycle inherent operation. Push, pull and both transfers take 4 cycles and return takes 5. `done` is high only in the last cycle, and `busy` falls after it.
- R4: Push, cycle 3: a write with VMA high to address SP, with `dataOe` high and `dataOut` equal to `acc`. Cycle 4 presents SP-1 with VMA low. SP ends decremented by 1.
- R5: Pull, cycle 3: address SP with VMA low. Cycle 4: a read with VMA high from SP+1, whose data is loaded into `acc`. SP ends incremented by 1.
- R6: Return, cycle 3: address SP with VMA low. Cycle 4: a read from SP+1, giving the high byte. Cycle 5: a read from SP+2, giving the low byte. At the end of cycle 5, `pc` becomes {high, low} and SP has grown by 2.
- R7: Stack-pointer-to-index, cycle 3: address SP. Cycle 4: the new index value SP+1. VMA is low in both cycles, the index ends as SP+1, and SP is unchanged.
- R8: Index-to-stack-pointer, cycle 3: the index register. Cycle 4: the new stack pointer X-1. VMA is low in both cycles and SP ends as X-1.
- R9: `rw` is 1 in every cycle except the push data write. `dataOe` is high only in that write cycle.
- R10: Every instruction other than return leaves `pc` at `opcAddrIn`+1.
- R11: `start` while an instruction is running has no effect. The running sequence completes unchanged and the block goes idle after `done`.
- R12: All address and register arithmetic is modulo 2^16. Examples: X=0x0000 gives SP=0xFFFF, a push at 0xFFFF leaves 0xFFFE, and SP=0xFFFF gives X=0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the instruction in `op` (honoured only when idle) |
| op | input | 3 | Instruction code |
| opcAddrIn | input | 16 | Address the opcode was fetched from |
| dataIn | input | 8 | Read data from memory |
| addr | output | 16 | Bus address |
| vma | output | 1 | Valid memory address |
| rw | output | 1 | 1 = read, 0 = write |
| dataOut | output | 8 | Write data |
| dataOe | output | 1 | Write data driver enable |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction |
| sp | output | 16 | Stack pointer |
| ix | output | 16 | Index register |
| acc | output | 8 | Accumulator |
| pc | output | 16 | Program counter |

## Verification
The assertions assume `start` is only meaningful while `busy` is low. They also assume `dataIn` is valid in every cycle in which the block reads with VMA high. The stimulus drives these inputs half a cycle away from the sampling edge. Any `start` it raises during a running instruction is there to show that the pulse is ignored. The bench memory always returns a defined byte, so the pull and return loads compare against known contents. The wraparound cases come from a second reset that brings the index register back to zero, rather than from any extra load path into the registers.

// File: rtl/stackseq_pkg.sv
package stackseq_pkg;

  typedef enum logic [2:0] {
    OP_SIMPLE = 3'd0,
    OP_PUSH   = 3'd1,
    OP_PULL   = 3'd2,
    OP_RETURN = 3'd3,
    OP_SP2IX  = 3'd4,
    OP_IX2SP  = 3'd5
  } opCode_e;

  typedef enum logic [1:0] {
    ASEL_OPC  = 2'd0,
    ASEL_OPC1 = 2'd1,
    ASEL_SP   = 2'd2,
    ASEL_IX   = 2'd3
  } addrSel_e;

  // control -> datapath strobes for one bus cycle
  typedef struct packed {
    addrSel_e addrSel;
    logic     vma;
    logic     rd;
    logic     drive;
    logic     spInc;
    logic     spDec;
    logic     spFromIx;
    logic     ixFromSp;
    logic     accLoad;
    logic     hiLoad;
    logic     pcRet;
    logic     pcNext;
    logic     capture;
  } strobe_t;

  localparam int MAX_CYCLES = 5;

endpackage

// File: rtl/stackseq_ctrl.sv
module stackseq_ctrl
  import stackseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] op,
  output strobe_t    stb,
  output logic       busy,
  output logic       done
);

  localparam int CW = $clog2(MAX_CYCLES + 1);

  logic [CW-1:0] cycle;
  opCode_e       opReg;
  logic [CW-1:0] cycLen;

  always_comb begin
    case (opReg)
      OP_PUSH, OP_PULL, OP_SP2IX, OP_IX2SP: cycLen = CW'(4);
      OP_RETURN:                            cycLen = CW'(5);
      default:                              cycLen = CW'(2);
    endcase
  end

  assign busy = (cycle != '0);
  assign done = busy && (cycle == cycLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycle <= '0;
      opReg <= OP_SIMPLE;
    end else if (!busy) begin
      if (start) begin
        cycle <= CW'(1);
        opReg <= opCode_e'(op);
      end
    end else if (done) begin
      cycle <= '0;
    end else begin
      cycle <= cycle + CW'(1);
    end
  end

  always_comb begin
    stb          = '0;
    stb.addrSel  = ASEL_OPC;
    stb.rd       = 1'b1;
    stb.capture  = !busy && start;
    case (cycle)
      CW'(1): stb.vma = 1'b1;
      CW'(2): begin
        stb.addrSel = ASEL_OPC1;
        stb.vma     = 1'b1;
        stb.pcNext  = done;
      end
      CW'(3): begin
        case (opReg)
          OP_PUSH: begin
            stb.addrSel = ASEL_SP;
            stb.vma     = 1'b1;
            stb.rd      = 1'b0;
            stb.drive   = 1'b1;
            stb.spDec   = 1'b1;
          end
          OP_PULL, OP_RETURN: begin
            stb.addrSel = ASEL_SP;
            stb.spInc   = 1'b1;
          end
          OP_SP2IX: begin
            stb.addrSel  = ASEL_SP;
            stb.ixFromSp = 1'b1;
          end
          OP_IX2SP: begin
            stb.addrSel  = ASEL_IX;
            stb.spFromIx = 1'b1;
          end
          default: ;
        endcase
      end
      CW'(4): begin
        stb.pcNext = (opReg != OP_RETURN);
        case (opReg)
          OP_PUSH, OP_IX2SP: stb.addrSel = ASEL_SP;
          OP_SP2IX:          stb.addrSel = ASEL_IX;
          OP_PULL: begin
            stb.addrSel = ASEL_SP;
            stb.vma     = 1'b1;
            stb.accLoad = 1'b1;
          end
          OP_RETURN: begin
            stb.addrSel = ASEL_SP;
            stb.vma     = 1'b1;
            stb.hiLoad  = 1'b1;
            stb.spInc   = 1'b1;
          end
          default: ;
        endcase
      end
      CW'(5): begin
        stb.addrSel = ASEL_SP;
        stb.vma     = 1'b1;
        stb.pcRet   = 1'b1;
      end
      default: ;
    endcase
  end

  // R3: the last cycle always returns to idle
  a_r3_done_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  // R11: a running sequence only ever steps forward, whatever start does
  a_r11_steps_forward: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> (busy && cycle == $past(cycle) + CW'(1)));
  // R9: a write cycle is always a valid, driven cycle
  a_r9_write_valid: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rd |-> (stb.vma && stb.drive));
  // R3: no instruction runs past five cycles
  a_r3_max_len: assert property (@(posedge clk) disable iff (!rstN)
    cycle <= CW'(MAX_CYCLES));

endmodule

// File: rtl/stackseq_datapath.sv
module stackseq_datapath
  import stackseq_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] SP_INIT  = 16'h00F0,
  parameter logic [ADDR_W-1:0] IX_INIT  = 16'h0000,
  parameter logic [DATA_W-1:0] ACC_INIT = 8'h5A,
  parameter logic [ADDR_W-1:0] PC_INIT  = 16'h0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] opcAddrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addr,
  output logic              vma,
  output logic              rw,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] ix,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] opcAddr;
  logic [DATA_W-1:0] hiByte;

  always_comb begin
    case (stb.addrSel)
      ASEL_OPC1: addr = opcAddr + ONE;
      ASEL_SP:   addr = sp;
      ASEL_IX:   addr = ix;
      default:   addr = opcAddr;
    endcase
  end

  assign vma     = stb.vma;
  assign rw      = stb.rd;
  assign dataOe  = stb.drive;
  assign dataOut = stb.drive ? acc : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcAddr <= PC_INIT;
      hiByte  <= '0;
      sp      <= SP_INIT;
      ix      <= IX_INIT;
      acc     <= ACC_INIT;
      pc      <= PC_INIT;
    end else begin
      if (stb.capture)  opcAddr <= opcAddrIn;
      if (stb.hiLoad)   hiByte  <= dataIn;
      if (stb.accLoad)  acc     <= dataIn;
      if (stb.spInc)         sp <= sp + ONE;
      else if (stb.spDec)    sp <= sp - ONE;
      else if (stb.spFromIx) sp <= ix - ONE;
      if (stb.ixFromSp) ix <= sp + ONE;
      if (stb.pcRet)       pc <= {hiByte, dataIn};
      else if (stb.pcNext) pc <= opcAddr + ONE;
    end
  end

  // R4: the push write lands at the current stack pointer with the accumulator
  a_r4_write_at_sp: assert property (@(posedge clk) disable iff (!rstN)
    !rw |-> (addr == sp && dataOut == acc && dataOe));
  // R4: the cycle after a push write sees the stack pointer one lower
  a_r4_sp_dec: assert property (@(posedge clk) disable iff (!rstN)
    !rw |=> (sp == $past(sp) - ONE));
  // R6: return target is assembled from the two stack reads
  a_r6_pc_from_stack: assert property (@(posedge clk) disable iff (!rstN)
    stb.pcRet |=> (pc == {$past(hiByte), $past(dataIn)}));
  // R7: the index transfer leaves the stack pointer alone
  a_r7_sp_kept: assert property (@(posedge clk) disable iff (!rstN)
    stb.ixFromSp |=> (ix == $past(sp) + ONE && sp == $past(sp)));

endmodule

// File: rtl/stackseq.sv
module stackseq
  import stackseq_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] SP_INIT  = 16'h00F0,
  parameter logic [ADDR_W-1:0] IX_INIT  = 16'h0000,
  parameter logic [DATA_W-1:0] ACC_INIT = 8'h5A,
  parameter logic [ADDR_W-1:0] PC_INIT  = 16'h0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] opcAddrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addr,
  output logic              vma,
  output logic              rw,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] ix,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc
);

  strobe_t stb;

  stackseq_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .op    (op),
    .stb   (stb),
    .busy  (busy),
    .done  (done)
  );

  stackseq_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SP_INIT  (SP_INIT),
    .IX_INIT  (IX_INIT),
    .ACC_INIT (ACC_INIT),
    .PC_INIT  (PC_INIT)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .opcAddrIn (opcAddrIn),
    .dataIn    (dataIn),
    .addr      (addr),
    .vma       (vma),
    .rw        (rw),
    .dataOut   (dataOut),
    .dataOe    (dataOe),
    .sp        (sp),
    .ix        (ix),
    .acc       (acc),
    .pc        (pc)
  );

  // R2: the first cycle of an instruction is a valid read
  a_r2_first_fetch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (vma && rw));
  // R2: the second cycle presents the following address
  a_r2_second_fetch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> (addr == $past(addr) + ADDR_W'(1) && vma && rw));
  // R1: nothing valid on the bus while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!vma && rw && !dataOe));

endmodule

// File: tb/stackseq_test.sv
module stackseq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] opcAddrIn = 16'h0;
  logic [7:0]  dataIn;
  logic [15:0] addr, sp, ix, pc;
  logic        vma, rw, dataOe, busy, done;
  logic [7:0]  dataOut, acc;

  logic [7:0] mem [256];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stackseq uut (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .opcAddrIn(opcAddrIn),
    .dataIn(dataIn), .addr(addr), .vma(vma), .rw(rw), .dataOut(dataOut),
    .dataOe(dataOe), .busy(busy), .done(done), .sp(sp), .ix(ix), .acc(acc),
    .pc(pc)
  );

  assign dataIn = mem[addr[7:0]];
  always @(posedge clk) if (vma && !rw) mem[addr[7:0]] <= dataOut;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // compare one bus cycle, then move to the next sample point
  task automatic busCycle(string req, logic [15:0] a, logic v, logic r,
                          logic last, logic [7:0] wdata);
    check({req, " addr"}, 32'(addr), 32'(a));
    check({req, " vma"},  32'(vma),  32'(v));
    check({req, " rw R9"}, 32'(rw),  32'(r));
    check({req, " dataOe R9"}, 32'(dataOe), 32'(!r));
    check({req, " done R3"}, 32'(done), 32'(last));
    if (!r) check({req, " wdata"}, 32'(dataOut), 32'(wdata));
    @(negedge clk);
  endtask

  task automatic launch(logic [2:0] code, logic [15:0] at);
    @(negedge clk);
    start = 1'b1; op = code; opcAddrIn = at;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic fetchPair(string req, logic [15:0] at, logic shortOp);
    busCycle({req, " c1 R2"}, at, 1'b1, 1'b1, 1'b0, 8'h00);
    busCycle({req, " c2 R2"}, at + 16'd1, 1'b1, 1'b1, shortOp, 8'h00);
  endtask

  task automatic endRegs(string req, logic [15:0] eSp, logic [15:0] eIx,
                         logic [7:0] eAcc, logic [15:0] ePc);
    check({req, " busy R3"}, 32'(busy), 32'h0);
    check({req, " sp"},  32'(sp),  32'(eSp));
    check({req, " ix"},  32'(ix),  32'(eIx));
    check({req, " acc"}, 32'(acc), 32'(eAcc));
    check({req, " pc R10"}, 32'(pc), 32'(ePc));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 busy", 32'(busy), 32'h0);
    check("R1 vma",  32'(vma),  32'h0);
    check("R1 rw",   32'(rw),   32'h1);
    check("R1 oe",   32'(dataOe), 32'h0);
    check("R1 sp",   32'(sp),   32'h00F0);
    check("R1 ix",   32'(ix),   32'h0000);
    check("R1 acc",  32'(acc),  32'h5A);
    check("R1 pc",   32'(pc),   32'h0000);
    rstN = 1'b1;
  endtask

  task automatic testSimple(logic [2:0] code, logic [15:0] at);
    launch(code, at);
    fetchPair("R3 simple", at, 1'b1);
    endRegs("R3 simple", sp, ix, acc, at + 16'd1);
  endtask

  task automatic testPush(logic [15:0] at, logic holdStart);
    logic [15:0] s0 = sp;
    logic [7:0]  a0 = acc;
    logic [15:0] x0 = ix;
    launch(3'd1, at);
    if (holdStart) begin
      start = 1'b1; op = 3'd3; opcAddrIn = 16'h4000;   // R11 stray start
    end
    fetchPair("R4 push", at, 1'b0);
    busCycle("R4 push c3 write", s0, 1'b1, 1'b0, 1'b0, a0);
    busCycle("R4 push c4", s0 - 16'd1, 1'b0, 1'b1, 1'b1, 8'h00);
    start = 1'b0;
    check("R11 idle after push", 32'(busy), 32'h0);
    check("R4 mem", 32'(mem[s0[7:0]]), 32'(a0));
    endRegs("R4 push", s0 - 16'd1, x0, a0, at + 16'd1);
  endtask

  task automatic testPull(logic [15:0] at, logic [7:0] val);
    logic [15:0] s0 = sp;
    logic [15:0] x0 = ix;
    logic [15:0] nxt = s0 + 16'd1;
    mem[nxt[7:0]] = val;
    launch(3'd2, at);
    fetchPair("R5 pull", at, 1'b0);
    busCycle("R5 pull c3", s0, 1'b0, 1'b1, 1'b0, 8'h00);
    busCycle("R5 pull c4", nxt, 1'b1, 1'b1, 1'b1, 8'h00);
    endRegs("R5 pull", nxt, x0, val, at + 16'd1);
  endtask

  task automatic testReturn(logic [15:0] at, logic [15:0] target);
    logic [15:0] s0 = sp;
    logic [15:0] x0 = ix;
    logic [7:0]  a0 = acc;
    logic [15:0] p1 = s0 + 16'd1;
    logic [15:0] p2 = s0 + 16'd2;
    mem[p1[7:0]] = target[15:8];
    mem[p2[7:0]] = target[7:0];
    launch(3'd3, at);
    fetchPair("R6 ret", at, 1'b0);
    busCycle("R6 ret c3", s0, 1'b0, 1'b1, 1'b0, 8'h00);
    busCycle("R6 ret c4", p1, 1'b1, 1'b1, 1'b0, 8'h00);
    busCycle("R6 ret c5", p2, 1'b1, 1'b1, 1'b1, 8'h00);
    endRegs("R6 ret", p2, x0, a0, target);
  endtask

  task automatic testSp2Ix(logic [15:0] at);
    logic [15:0] s0 = sp;
    logic [7:0]  a0 = acc;
    launch(3'd4, at);
    fetchPair("R7 sp2ix", at, 1'b0);
    busCycle("R7 sp2ix c3", s0, 1'b0, 1'b1, 1'b0, 8'h00);
    busCycle("R7 sp2ix c4 R12", s0 + 16'd1, 1'b0, 1'b1, 1'b1, 8'h00);
    endRegs("R7 sp2ix", s0, s0 + 16'd1, a0, at + 16'd1);
  endtask

  task automatic testIx2Sp(logic [15:0] at);
    logic [15:0] x0 = ix;
    logic [7:0]  a0 = acc;
    launch(3'd5, at);
    fetchPair("R8 ix2sp", at, 1'b0);
    busCycle("R8 ix2sp c3", x0, 1'b0, 1'b1, 1'b0, 8'h00);
    busCycle("R8 ix2sp c4 R12", x0 - 16'd1, 1'b0, 1'b1, 1'b1, 8'h00);
    endRegs("R8 ix2sp", x0 - 16'd1, x0, a0, at + 16'd1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    @(negedge clk);
    doReset();
    testSimple(3'd0, 16'h2000);
    testSimple(3'd7, 16'h3000);
    testPush(16'h1000, 1'b0);          // SP F0 -> EF
    testPull(16'h1010, 8'hA7);         // SP EF -> F0, acc A7
    testReturn(16'h1020, 16'h1234);    // SP F0 -> F2
    testSp2Ix(16'h1234);               // X = F3
    testPush(16'h1100, 1'b1);          // R11, SP F2 -> F1
    testIx2Sp(16'h1200);               // SP = F2
    doReset();
    testIx2Sp(16'h0500);               // R12: SP = FFFF
    testPush(16'h0510, 1'b0);          // R12: write at FFFF, SP FFFE
    testPull(16'h0520, 8'h3C);         // R12: read FFFF
    testSp2Ix(16'h0530);               // R12: X = 0000
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule